// File: doc/BRIEF.md
# Timer Pin GPIO Interrupt Selector

This block sits between a timer core and the timer's two external pins, one input pin and one output pin. A 32-bit control word, written and read over a simple register port, decides two things for each pin. The first is whether the pin serves the timer or acts as a general-purpose I/O. The second is whether the interrupt/event line that the system sees comes from the timer's own event or from an edge detected on that pin.

When a pin drives the interrupt/event line, the pin level passes through a two-flop synchroniser. An edge of the chosen polarity then produces a pulse one clock long. The timer's counting logic and the GPIO data and direction registers live outside this block. The block only routes pin levels and selects the interrupt/event sources.

Top module: `tmr_pin_irq_sel`

## Requirements
- R1: After reset the control word reads 0. Each interrupt/event output equals its timer event input, `out_pin` equals `tmr_out_lvl`, and `gpio_in` is 0.
- R2: A write with `cfg_we` high stores only bits 0, 1, 4, 5, 16 and 17 of `cfg_wdata`. `cfg_rdata` shows these bits in the cycle after the write, and every other bit of `cfg_rdata` reads 0.
- R3: Bit 17 picks the output pin function. When it is 0, `out_pin` equals `tmr_out_lvl`. When it is 1, `out_pin` equals `gpio_out_lvl`.
- R4: Bit 16 picks the input pin function. When it is 0, the synchronised `in_pin` level appears on `tmr_in` and `gpio_in` is 0. When it is 1, the level appears on `gpio_in` and `tmr_in` is 0. The level appears two clock edges after `in_pin` changes.
- R5: Bit 0 picks the source of `irq_in_path`. When it is 0, `irq_in_path` follows `tmr_evt_in` in the same cycle. When it is 1, `irq_in_path` carries pulses from edges on `in_pin`, and `tmr_evt_in` has no effect on it.
- R6: Bit 1 picks the source of `irq_out_path` in the same way. The choice is between `tmr_evt_out` and edges on `out_pin`.
- R7: Bit 4 sets the edge polarity of the input path and bit 5 sets it for the output path. A value of 0 selects a rising edge and 1 selects a falling edge. An edge of the other polarity produces no pulse.
- R8: A selected edge produces a pulse exactly one clock long. The pulse is visible after the second rising clock edge that follows the pin change.
- R9: A control write that changes the enable or polarity bits while the pin is steady produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| in_pin | input | 1 | External timer input pin level |
| tmr_in | output | 1 | Synchronised input pin level to timer core |
| gpio_in | output | 1 | Synchronised input pin level to GPIO logic |
| tmr_out_lvl | input | 1 | Output level from timer core |
| gpio_out_lvl | input | 1 | Output level from GPIO logic |
| out_pin | output | 1 | Level driven on external output pin |
| tmr_evt_in | input | 1 | Timer event for input-pin path |
| tmr_evt_out | input | 1 | Timer event for output-pin path |
| irq_in_path | output | 1 | Interrupt/event line for input-pin path |
| irq_out_path | output | 1 | Interrupt/event line for output-pin path |

## Verification
Each pin path is driven through rising and falling transitions under both polarity settings. This shows that only the selected edge produces a pulse, and that the pulse has the expected latency and length. The timer event inputs are toggled with each source selection: in timer mode they must pass straight through, and in pin mode they must have no effect. Both pin-function settings are checked by sending distinct levels from the timer and GPIO sides. Enable and polarity writes made while a pin is held high check that a configuration change alone never pulses.

// File: rtl/tps_pkg.sv
package tps_pkg;
    localparam int unsigned CFG_W = 32;
    localparam int unsigned NCH   = 2;   // channel 0: input pin, 1: output pin
    localparam int unsigned B_EN_IN   = 0;
    localparam int unsigned B_EN_OUT  = 1;
    localparam int unsigned B_INV_IN  = 4;
    localparam int unsigned B_INV_OUT = 5;
    localparam int unsigned B_GP_IN   = 16;
    localparam int unsigned B_GP_OUT  = 17;
    localparam logic [CFG_W-1:0] CFG_MASK =
        (CFG_W'(1) << B_EN_IN)  | (CFG_W'(1) << B_EN_OUT)  |
        (CFG_W'(1) << B_INV_IN) | (CFG_W'(1) << B_INV_OUT) |
        (CFG_W'(1) << B_GP_IN)  | (CFG_W'(1) << B_GP_OUT);

    typedef struct packed {
        logic [NCH-1:0] gp;    // pin used as GPIO
        logic [NCH-1:0] inv;   // falling edge select
        logic [NCH-1:0] en;    // pin edge sources the interrupt/event
    } tps_cfg_t;
endpackage

// File: rtl/tps_cfg_reg.sv
module tps_cfg_reg
    import tps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output tps_cfg_t         cfg,
    output logic [CFG_W-1:0] rdata
);
    tps_cfg_t cfg_d, cfg_q;
    logic unused_wbits;

    assign unused_wbits = ^(wdata & ~CFG_MASK);

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.en  = {wdata[B_EN_OUT],  wdata[B_EN_IN]};
            cfg_d.inv = {wdata[B_INV_OUT], wdata[B_INV_IN]};
            cfg_d.gp  = {wdata[B_GP_OUT],  wdata[B_GP_IN]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        rdata[B_EN_IN]   = cfg_q.en[0];
        rdata[B_EN_OUT]  = cfg_q.en[1];
        rdata[B_INV_IN]  = cfg_q.inv[0];
        rdata[B_INV_OUT] = cfg_q.inv[1];
        rdata[B_GP_IN]   = cfg_q.gp[0];
        rdata[B_GP_OUT]  = cfg_q.gp[1];
    end

    assign cfg = cfg_q;

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rdata));
endmodule

// File: rtl/tps_sync.sv
module tps_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.chain[0] = din;
        for (int i = 1; i < STAGES; i++) st_d.chain[i] = st_q.chain[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.chain[STAGES-1];
endmodule

// File: rtl/tps_edge.sv
module tps_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic en,
    input  logic inv,
    output logic pulse
);
    typedef struct packed {
        logic prev;
        logic en_old;
        logic inv_old;
    } edge_t;

    edge_t st_d, st_q;
    logic  cfg_chg;
    logic  hit;

    always_comb begin
        cfg_chg    = (en != st_q.en_old) || (inv != st_q.inv_old);
        hit        = inv ? (st_q.prev & ~lvl) : (~st_q.prev & lvl);
        pulse      = en & ~cfg_chg & hit;
        st_d.prev    = lvl;
        st_d.en_old  = en;
        st_d.inv_old = inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    // R5
    pulse_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> en);
    // R7
    pulse_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (lvl != $past(lvl)) && (lvl == !inv));
    // R9
    pulse_cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en != $past(en) || inv != $past(inv)) |-> !pulse);
endmodule

// File: rtl/tmr_pin_irq_sel.sv
module tmr_pin_irq_sel
    import tps_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        in_pin,
    output logic        tmr_in,
    output logic        gpio_in,
    input  logic        tmr_out_lvl,
    input  logic        gpio_out_lvl,
    output logic        out_pin,
    input  logic        tmr_evt_in,
    input  logic        tmr_evt_out,
    output logic        irq_in_path,
    output logic        irq_out_path
);
    tps_cfg_t       cfg;
    logic [NCH-1:0] pin_raw, pin_sync, pin_pulse, tmr_evt, irq;

    tps_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .cfg(cfg), .rdata(cfg_rdata)
    );

    assign out_pin = cfg.gp[1] ? gpio_out_lvl : tmr_out_lvl;
    assign pin_raw = {out_pin, in_pin};
    assign tmr_evt = {tmr_evt_out, tmr_evt_in};

    tps_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_raw), .dout(pin_sync)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tps_edge u_edge (
            .clk(clk), .rst_n(rst_n), .lvl(pin_sync[c]),
            .en(cfg.en[c]), .inv(cfg.inv[c]), .pulse(pin_pulse[c])
        );
        assign irq[c] = cfg.en[c] ? pin_pulse[c] : tmr_evt[c];
    end

    assign tmr_in       = cfg.gp[0] ? 1'b0 : pin_sync[0];
    assign gpio_in      = cfg.gp[0] ? pin_sync[0] : 1'b0;
    assign irq_in_path  = irq[0];
    assign irq_out_path = irq[1];

    // R4
    in_route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tmr_in && gpio_in));
    // R3
    out_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[17] && $stable(gpio_out_lvl)) |-> $stable(out_pin) || $changed(cfg_rdata));
endmodule

// File: tb/tmr_pin_irq_sel_test.sv
module tmr_pin_irq_sel_test;
    logic        clk = 0, rst_n = 0;
    logic        cfg_we = 0;
    logic [31:0] cfg_wdata = 0, cfg_rdata;
    logic        in_pin = 0, tmr_in, gpio_in;
    logic        tmr_out_lvl = 0, gpio_out_lvl = 0, out_pin;
    logic        tmr_evt_in = 0, tmr_evt_out = 0;
    logic        irq_in_path, irq_out_path;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    tmr_pin_irq_sel uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .in_pin(in_pin), .tmr_in(tmr_in), .gpio_in(gpio_in),
        .tmr_out_lvl(tmr_out_lvl), .gpio_out_lvl(gpio_out_lvl), .out_pin(out_pin),
        .tmr_evt_in(tmr_evt_in), .tmr_evt_out(tmr_evt_out),
        .irq_in_path(irq_in_path), .irq_out_path(irq_out_path)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); cfg_we = 1; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
        repeat (3) @(negedge clk);   // let edge logic settle
    endtask

    function automatic logic irq_of(input int ch);
        return ch == 0 ? irq_in_path : irq_out_path;
    endfunction

    task automatic set_pin(input int ch, input logic v);
        if (ch == 0) in_pin = v; else gpio_out_lvl = v;
    endtask

    // pin change at negedge; expect pulse after second posedge, one cycle long
    task automatic edge_seq(input int ch, input logic v, input logic expect_p, input string req);
        @(negedge clk); set_pin(ch, v);
        @(negedge clk); chk(req, irq_of(ch), 0);
        @(negedge clk); chk(req, irq_of(ch), expect_p);
        @(negedge clk); chk(req, irq_of(ch), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 rdata", cfg_rdata, 0);
        tmr_evt_in = 1; tmr_out_lvl = 1; #0.1;
        chk("R1 irq_in", irq_in_path, 1);
        chk("R1 out_pin", out_pin, 1);
        chk("R1 gpio_in", gpio_in, 0);
        tmr_evt_in = 0; tmr_out_lvl = 0;
    endtask

    task automatic t_regs;
        wr(32'hFFFF_FFFF);
        chk("R2 mask", cfg_rdata, 32'h0003_0033);
        wr(32'h0002_0010);
        chk("R2 partial", cfg_rdata, 32'h0002_0010);
        wr(0);
        chk("R2 clear", cfg_rdata, 0);
    endtask

    task automatic t_out_mode;
        tmr_out_lvl = 1; gpio_out_lvl = 0; #0.1;
        chk("R3 timer", out_pin, 1);
        wr(32'h0002_0000);
        chk("R3 gpio", out_pin, 0);
        gpio_out_lvl = 1; #0.1;
        chk("R3 gpio hi", out_pin, 1);
        wr(0); tmr_out_lvl = 0; gpio_out_lvl = 0;
    endtask

    task automatic t_in_mode;
        @(negedge clk); in_pin = 1;
        @(negedge clk); chk("R4 lat", tmr_in, 0);
        @(negedge clk); chk("R4 timer", tmr_in, 1);
        chk("R4 gpio0", gpio_in, 0);
        wr(32'h0001_0000);
        chk("R4 gpio", gpio_in, 1);
        chk("R4 timer0", tmr_in, 0);
        wr(0);
        @(negedge clk); in_pin = 0; repeat (3) @(negedge clk);
    endtask

    task automatic t_src;
        tmr_evt_in = 1; tmr_evt_out = 1; #0.1;
        chk("R5 timer", irq_in_path, 1);
        chk("R6 timer", irq_out_path, 1);
        wr(32'h0002_0003);
        chk("R5 ignore", irq_in_path, 0);
        chk("R6 ignore", irq_out_path, 0);
        tmr_evt_in = 0; tmr_evt_out = 0;
    endtask

    task automatic t_edges(input int ch);
        // rising polarity, with ch enable; bit17 set so gpio_out_lvl drives out_pin
        wr(32'h0002_0003);
        edge_seq(ch, 1, 1, "R7 R8 rise");
        edge_seq(ch, 0, 0, "R7 fall ignored");
        wr(ch == 0 ? 32'h0002_0013 : 32'h0002_0023);
        edge_seq(ch, 1, 0, "R7 rise ignored");
        edge_seq(ch, 0, 1, "R7 R8 fall");
        wr(0);
    endtask

    task automatic t_quiet;
        @(negedge clk); in_pin = 1; repeat (3) @(negedge clk);
        @(negedge clk); cfg_we = 1; cfg_wdata = 32'h1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); cfg_we = 0;
            chk("R9 enable", irq_in_path, 0);
        end
        @(negedge clk); cfg_we = 1; cfg_wdata = 32'h11;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); cfg_we = 0;
            chk("R9 polarity", irq_in_path, 0);
        end
        wr(0); in_pin = 0; repeat (3) @(negedge clk);
    endtask

    initial begin
        #50000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_regs;
        t_out_mode;
        t_in_mode;
        t_src;
        t_edges(0);
        t_edges(1);
        t_quiet;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule